// File: doc/BRIEF.md
# Watchdog / Interval Timer with Configuration Lock

This block is a single up-counter that serves two roles. The count clock is taken from a free-running prescaler on the base clock: a 3-bit tap select picks a power-of-two division factor. In interval mode, every wrap of the counter from all-ones to zero gives a one-cycle maskable interrupt pulse, so the block acts as a periodic tick source. In watchdog mode, the same wrap is a timeout. Depending on an action bit, the timeout either raises a non-maskable interrupt request or sends a one-cycle system reset request.

Software configures the block with single-cycle writes that carry the tap, the mode bit, the action bit and the run bit. A write with run set clears the counter and the prescaler. In watchdog mode this write is the "kick" that restarts the timeout window. Once watchdog mode is running, the configuration is frozen until the next reset. After that point, software can only restart the count. It cannot stop the timer or change the tap, the mode or the action. The NMI request stays asserted until the interrupt logic acknowledges it.

Top module: `guard_timer`

## Requirements
- R1: After a synchronous reset, `tick_irq`, `nmi_req` and `rst_req` are 0, the stored tap, mode, action and run bits are all 0, and the timer stays stopped (no event appears) until a write sets the run bit.
- R2: The count clock is one tick every 2^(MIN_SHIFT+tap) base cycles. Tap values above MAX_SHIFT-MIN_SHIFT saturate at 2^MAX_SHIFT; with the defaults, tap 6 and tap 7 both give 2^9.
- R3: A write with `cfg_run`=1 clears the counter and the prescaler at its capturing edge. The first wrap from all-ones to zero takes effect on the edge 2^CNT_W * 2^shift base cycles later, where shift is the saturated value of MIN_SHIFT+tap from R2. Wraps then repeat with that same period.
- R4: In interval mode (`cfg_wdog`=0), each wrap gives a one-cycle `tick_irq` pulse, registered one edge after the wrap is detected. Neither `nmi_req` nor `rst_req` is raised, and at most one of the three outputs is high at any time.
- R5: In watchdog mode with `cfg_act_rst`=0, a wrap sets `nmi_req`. It stays high until `nmi_ack` is high at a clock edge. If a wrap and an acknowledge fall on the same edge, the request is set.
- R6: In watchdog mode with `cfg_act_rst`=1, a wrap gives a one-cycle `rst_req` pulse and does not raise `nmi_req`.
- R7: While the stored watchdog bit and run bit are both 1, writes do not change the tap, mode, action or run bits. A write with `cfg_run`=1 still restarts the count as in R3, and a write with `cfg_run`=0 has no effect at all.
- R8: In interval mode, a write with `cfg_run`=0 stops the timer: no event is produced while it is stopped.
- R9: Only a reset releases the lock of R7; after reset, the block accepts a new interval-mode setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_tap | input | 3 | Prescaler tap select |
| cfg_wdog | input | 1 | 1 = watchdog mode, 0 = interval mode |
| cfg_act_rst | input | 1 | Watchdog action: 1 = reset request, 0 = NMI request |
| cfg_run | input | 1 | 1 = run and clear the count, 0 = stop |
| nmi_ack | input | 1 | Clears a pending NMI request |
| rst_req | output | 1 | One-cycle system reset request |
| nmi_req | output | 1 | Held non-maskable interrupt request |
| tick_irq | output | 1 | One-cycle interval interrupt |

## Verification
The bench builds the block with CNT_W=4 and the default MIN_SHIFT=3 and MAX_SHIFT=9. With these values a full timeout lasts between 128 and 8192 base cycles. Every tap, including the two saturated taps at the slowest division, can therefore be checked to the exact cycle. Random interval setups are checked over two consecutive periods. Directed runs cover the NMI hold and the acknowledge race, the reset pulse, kicks and ignored writes under the lock, stopping the timer, and release of the lock by reset.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int TAP_W = 3;

  typedef struct packed {
    logic [TAP_W-1:0] tap;
    logic             wdog;
    logic             act_rst;
    logic             run;
  } gt_cfg_t;
endpackage

// File: rtl/gt_ctrl.sv
module gt_ctrl
  import gt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  gt_cfg_t wr,
  output gt_cfg_t cfg,
  output logic    restart,
  output logic    locked
);
  assign locked  = cfg.wdog & cfg.run;
  assign restart = we & wr.run;

  always_ff @(posedge clk) begin
    if (rst)
      cfg <= '0;
    else if (we && !locked)
      cfg <= wr;
  end

  // R1: configuration is cleared by reset
  a_r1_cfg_reset: assert property (@(posedge clk) $past(rst) |-> (cfg == '0));
  // R7: a locked configuration never changes
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    locked |=> (cfg == $past(cfg)));
endmodule

// File: rtl/gt_prescale.sv
module gt_prescale
  import gt_pkg::*;
#(
  parameter int MIN_SHIFT = 3,
  parameter int MAX_SHIFT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [TAP_W-1:0] tap,
  output logic             tick
);
  localparam int NTAP = MAX_SHIFT - MIN_SHIFT + 1;

  logic [MAX_SHIFT-1:0] pre;
  logic [NTAP-1:0]      hit;
  int                   eff;

  always_ff @(posedge clk) begin
    if (rst || restart)
      pre <= '0;
    else if (run)
      pre <= pre + 1'b1;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign hit[g] = &pre[MIN_SHIFT+g-1:0];
  end

  always_comb begin
    eff = (int'(tap) > NTAP - 1) ? NTAP - 1 : int'(tap);
    tick = 1'b0;
    for (int i = 0; i < NTAP; i++)
      if (i == eff) tick = run & hit[i];
  end
endmodule

// File: rtl/gt_count.sv
module gt_count #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic ovf
);
  logic [CNT_W-1:0] cnt;

  assign ovf = tick & ~restart & (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + 1'b1;
  end

  // R3: a detected wrap leaves the counter at zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == '0));
endmodule

// File: rtl/gt_event.sv
module gt_event (
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic wdog,
  input  logic act_rst,
  input  logic nmi_ack,
  output logic tick_irq,
  output logic rst_req,
  output logic nmi_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_irq <= 1'b0;
      rst_req  <= 1'b0;
      nmi_req  <= 1'b0;
    end else begin
      tick_irq <= ovf & ~wdog;
      rst_req  <= ovf & wdog & act_rst;
      if (ovf && wdog && !act_rst)
        nmi_req <= 1'b1;
      else if (nmi_ack)
        nmi_req <= 1'b0;
    end
  end

  // R4: interval pulses only follow interval mode; outputs are exclusive
  a_r4_irq_mode: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> !$past(wdog));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tick_irq, rst_req, nmi_req}));
  // R5: NMI request holds until acknowledged
  a_r5_nmi_hold: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && !nmi_ack) |=> nmi_req);
  // R6: reset request is a single-cycle pulse
  a_r6_rst_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MIN_SHIFT = 3,
  parameter int MAX_SHIFT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [TAP_W-1:0] cfg_tap,
  input  logic             cfg_wdog,
  input  logic             cfg_act_rst,
  input  logic             cfg_run,
  input  logic             nmi_ack,
  output logic             rst_req,
  output logic             nmi_req,
  output logic             tick_irq
);
  gt_cfg_t wr, cfg;
  logic    restart, locked, tick, ovf;

  assign wr.tap     = cfg_tap;
  assign wr.wdog    = cfg_wdog;
  assign wr.act_rst = cfg_act_rst;
  assign wr.run     = cfg_run;

  gt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .we(cfg_we), .wr(wr),
    .cfg(cfg), .restart(restart), .locked(locked)
  );

  gt_prescale #(.MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst(rst), .run(cfg.run), .restart(restart),
    .tap(cfg.tap), .tick(tick)
  );

  gt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick), .ovf(ovf)
  );

  gt_event u_evt (
    .clk(clk), .rst(rst), .ovf(ovf), .wdog(cfg.wdog),
    .act_rst(cfg.act_rst), .nmi_ack(nmi_ack),
    .tick_irq(tick_irq), .rst_req(rst_req), .nmi_req(nmi_req)
  );

  // R7: a lock, once taken, persists until reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
endmodule

// File: tb/tb_guard_timer.sv
module tb_guard_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int MIN_S = 3;
  localparam int MAX_S = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_wdog = 1'b0, cfg_act_rst = 1'b0, cfg_run = 1'b0;
  logic [2:0] cfg_tap = 3'd0;
  logic nmi_ack = 1'b0;
  logic rst_req, nmi_req, tick_irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  guard_timer #(.CNT_W(CNT_W), .MIN_SHIFT(MIN_S), .MAX_SHIFT(MAX_S)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tap(cfg_tap),
    .cfg_wdog(cfg_wdog), .cfg_act_rst(cfg_act_rst), .cfg_run(cfg_run),
    .nmi_ack(nmi_ack), .rst_req(rst_req), .nmi_req(nmi_req),
    .tick_irq(tick_irq)
  );

  function automatic int f_period(input int tap);
    int s;
    s = MIN_S + tap;
    if (s > MAX_S) s = MAX_S;
    return (1 << CNT_W) * (1 << s);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    nmi_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] tap, input logic w, input logic a,
                          input logic r, output int edge_n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tap = tap; cfg_wdog = w; cfg_act_rst = a; cfg_run = r;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    edge_n = cyc;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic count_events(input int n, output int ev);
    ev = 0;
    repeat (n) begin
      @(negedge clk);
      ev += int'(tick_irq | nmi_req | rst_req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w, k, x, p, ev;
    logic [2:0] sel;
    void'($urandom(32'd20240611));

    // R1: reset state and idle
    do_reset();
    chk("R1 tick_irq after reset", tick_irq, 1'b0);
    chk("R1 nmi_req after reset", nmi_req, 1'b0);
    chk("R1 rst_req after reset", rst_req, 1'b0);
    count_events(300, ev);
    chk("R1 stopped until run", ev == 0, 1'b1);

    // R3/R4: random interval setups over two periods
    for (int it = 0; it < 6; it++) begin
      do_reset();
      sel = 3'($urandom_range(0, 4));
      do_write(sel, 1'b0, 1'($urandom_range(0, 1)), 1'b1, w);
      p = f_period(int'(sel));
      wait_to(w + p - 1); chk("R3 no wrap before period", tick_irq, 1'b0);
      wait_to(w + p);     chk("R4 tick_irq at wrap", tick_irq, 1'b1);
      chk("R4 no nmi in interval mode", nmi_req, 1'b0);
      chk("R4 no rst in interval mode", rst_req, 1'b0);
      wait_to(w + p + 1); chk("R4 tick_irq one cycle", tick_irq, 1'b0);
      wait_to(w + 2*p);   chk("R3 periodic repeat", tick_irq, 1'b1);
    end

    // R2: saturated taps
    for (int t = 6; t < 8; t++) begin
      do_reset();
      do_write(3'(t), 1'b0, 1'b0, 1'b1, w);
      p = f_period(t);
      wait_to(w + p - 1); chk("R2 saturated tap early", tick_irq, 1'b0);
      wait_to(w + p);     chk("R2 saturated tap wrap", tick_irq, 1'b1);
    end

    // R5: NMI hold, acknowledge, set beats ack
    do_reset();
    do_write(3'd0, 1'b1, 1'b0, 1'b1, w);
    p = f_period(0);
    wait_to(w + p - 1); chk("R5 nmi before timeout", nmi_req, 1'b0);
    wait_to(w + p);     chk("R5 nmi at timeout", nmi_req, 1'b1);
    chk("R5 no irq in watchdog mode", tick_irq, 1'b0);
    chk("R5 no rst in nmi action", rst_req, 1'b0);
    wait_to(w + p + 5); chk("R5 nmi held", nmi_req, 1'b1);
    nmi_ack = 1'b1;
    wait_to(w + p + 6); nmi_ack = 1'b0;
    chk("R5 nmi cleared by ack", nmi_req, 1'b0);
    wait_to(w + 2*p - 1); nmi_ack = 1'b1;
    wait_to(w + 2*p);     nmi_ack = 1'b0;
    chk("R5 set wins over ack", nmi_req, 1'b1);
    wait_to(w + 2*p + 1); chk("R5 nmi still held", nmi_req, 1'b1);

    // R6: reset request pulse
    do_reset();
    do_write(3'd2, 1'b1, 1'b1, 1'b1, w);
    p = f_period(2);
    wait_to(w + p - 1); chk("R6 rst before timeout", rst_req, 1'b0);
    wait_to(w + p);     chk("R6 rst at timeout", rst_req, 1'b1);
    chk("R6 no nmi in reset action", nmi_req, 1'b0);
    wait_to(w + p + 1); chk("R6 rst one cycle", rst_req, 1'b0);

    // R7: kick restarts, other fields and stop ignored under lock
    do_reset();
    do_write(3'd0, 1'b1, 1'b0, 1'b1, w);
    p = f_period(0);
    wait_to(w + 60);
    do_write(3'd5, 1'b0, 1'b1, 1'b1, k);
    wait_to(k + 30);
    do_write(3'd3, 1'b0, 1'b0, 1'b0, x);
    wait_to(k + p - 1); chk("R7 kick delays timeout", nmi_req, 1'b0);
    wait_to(k + p);     chk("R7 locked nmi at kick+period", nmi_req, 1'b1);
    chk("R7 locked mode not interval", tick_irq, 1'b0);
    chk("R7 locked action not reset", rst_req, 1'b0);

    // R9: reset releases lock
    do_reset();
    do_write(3'd1, 1'b0, 1'b0, 1'b1, w);
    p = f_period(1);
    wait_to(w + p); chk("R9 interval after reset", tick_irq, 1'b1);
    chk("R9 no nmi after reset", nmi_req, 1'b0);

    // R8: stop in interval mode
    do_reset();
    do_write(3'd0, 1'b0, 1'b0, 1'b1, w);
    wait_to(w + 50);
    do_write(3'd0, 1'b0, 1'b0, 1'b0, x);
    count_events(400, ev);
    chk("R8 no event while stopped", ev == 0, 1'b1);
    do_write(3'd0, 1'b0, 1'b0, 1'b1, k);
    p = f_period(0);
    wait_to(k + p); chk("R8 restart after stop", tick_irq, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule